// File: doc/BRIEF.md
# Erase Command Sequencer

This block is the command front end of a parallel NOR flash, cut down to the erase commands and moved onto a synchronous bus. The bus has a write strobe with an address and a data byte, a read strobe, and an asynchronous active-low hardware reset. A command takes six writes. Two unlock writes come first, then an erase set-up write, then two more unlock writes, and then a final command write. The final write chooses between erasing the whole device and erasing selected sectors. A wrong address/data pair at any step drops the sequencer back to idle.

A chip erase goes straight into a simulated erase phase that covers every sector. A sector erase opens a timed acceptance window instead. Each write of the sector command inside the window adds the sector named by the top address bits to a sector mask and restarts the window. When the window runs out with no further sector command, the erase phase begins. Any other write in the window, apart from the suspend code, cancels the operation. While the window or the erase phase is active, reads return a status byte in place of array data. Writes are taken on every cycle that `wr_en` is high and are never held off, so the write port needs no back-pressure.

Top module: `erase_cmd_seq`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `win_open` and `erasing` are 0, `sect_mask` is 0, and a read returns 8'hFF.
- R2: A command starts only from these five writes in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55. Only address bits [10:0] are compared. A write that breaks the order returns the sequencer to idle, and no erase starts.
- R3: If the sixth write is 0x555/0x10, the erase phase starts on the next cycle with every bit of `sect_mask` set.
- R4: If the sixth write has data 0x30, the acceptance window opens and `busy` rises. The `sect_mask` bit chosen by address bits [ADDR_W-1 -: SECT_W] is set.
- R5: The window stays open for WIN_CYC cycles after the last accepted sector write. Each further 0x30 write restarts it. When the window expires, `erasing` is high for ERASE_CYC cycles.
- R6: Sectors may be added in any order. A repeated sector has no further effect. Every sector of the device can be queued.
- R7: A write in the window whose data is neither 0x30 nor 0xB0 returns the sequencer to idle and clears the mask. A 0xB0 write neither adds a sector nor restarts the window.
- R8: All writes during the erase phase are ignored. When the phase ends, the sequencer is idle and the mask is cleared.
- R9: While `busy` is high, a read returns a status byte. Bit 7 reads 0. Bit 6 flips after each read. Bit 3 is 1 only in the erase phase. All other bits read 0. When `busy` is low, a read returns 8'hFF.
- R10: Asserting `rst_n` during the window or the erase phase returns the sequencer to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, one command cycle per high clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command code |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Status byte while busy, 8'hFF otherwise |
| busy | output | 1 | High during the acceptance window and the erase phase |
| win_open | output | 1 | Acceptance window open |
| erasing | output | 1 | Simulated erase phase running |
| sect_mask | output | 2**SECT_W | Sectors selected for erase |

## Verification
The bench targets the window edge: it checks `win_open` on the last window cycle and `erasing` on the first erase cycle. A timer that is off by one, or that is not restarted by a late sector write, moves that change by a cycle. A suspend write is placed inside the window. A design that treats it as an abort would drop to idle, and one that treats it as a sector write would extend the window. A corrupted fifth unlock write, commands written during an erase, and a reset in mid-operation each have their own check, because a design that latches too early or too late shows a `busy` or a mask that should not be there. The status toggle bit is compared against a model on every read.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam int UNLK_W = 11;
  localparam logic [UNLK_W-1:0] A_KEY1 = 11'h555;
  localparam logic [UNLK_W-1:0] A_KEY2 = 11'h2AA;
  localparam logic [7:0] D_KEY1  = 8'hAA;
  localparam logic [7:0] D_KEY2  = 8'h55;
  localparam logic [7:0] D_SETUP = 8'h80;
  localparam logic [7:0] D_CHIP  = 8'h10;
  localparam logic [7:0] D_SECT  = 8'h30;
  localparam logic [7:0] D_SUSP  = 8'hB0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_SETUP, ST_K3, ST_K4, ST_WIN, ST_ERASE
  } seq_st_t;
endpackage

// File: rtl/esq_timer.sv
module esq_timer #(
  parameter int MAXV = 16,
  localparam int TW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  output logic [TW-1:0] cnt
);
  localparam logic [TW-1:0] TOP = TW'(MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (run && cnt < TOP) cnt <= cnt + 1'b1;
  end

  p_cnt_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
endmodule

// File: rtl/esq_fsm.sv
module esq_fsm
  import erase_seq_pkg::*;
#(
  parameter int WIN_CYC   = 8,
  parameter int ERASE_CYC = 16,
  parameter int TW        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [UNLK_W-1:0] key_addr,
  input  logic [7:0]        wr_data,
  input  logic [TW-1:0]     tcnt,
  output logic              tmr_rst,
  output logic              buf_set,
  output logic              buf_clr,
  output logic              chip_set,
  output logic              busy,
  output logic              win_open,
  output logic              erasing
);
  localparam logic [TW-1:0] WIN_LAST   = TW'(WIN_CYC - 1);
  localparam logic [TW-1:0] ERASE_LAST = TW'(ERASE_CYC - 1);

  seq_st_t st, nx;

  function automatic logic hit(input logic [UNLK_W-1:0] a, input logic [7:0] d,
                               input logic [UNLK_W-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  always_comb begin
    nx = st;
    tmr_rst = 1'b0;
    buf_set = 1'b0;
    buf_clr = 1'b0;
    chip_set = 1'b0;
    unique case (st)
      ST_IDLE:  if (wr_en && hit(key_addr, wr_data, A_KEY1, D_KEY1)) nx = ST_K1;
      ST_K1:    if (wr_en) nx = hit(key_addr, wr_data, A_KEY2, D_KEY2)  ? ST_K2    : ST_IDLE;
      ST_K2:    if (wr_en) nx = hit(key_addr, wr_data, A_KEY1, D_SETUP) ? ST_SETUP : ST_IDLE;
      ST_SETUP: if (wr_en) nx = hit(key_addr, wr_data, A_KEY1, D_KEY1)  ? ST_K3    : ST_IDLE;
      ST_K3:    if (wr_en) nx = hit(key_addr, wr_data, A_KEY2, D_KEY2)  ? ST_K4    : ST_IDLE;
      ST_K4: begin
        if (wr_en) begin
          if (hit(key_addr, wr_data, A_KEY1, D_CHIP)) begin
            nx = ST_ERASE;
            chip_set = 1'b1;
            tmr_rst = 1'b1;
          end else if (wr_data == D_SECT) begin
            nx = ST_WIN;
            buf_set = 1'b1;
            tmr_rst = 1'b1;
          end else begin
            nx = ST_IDLE;
          end
        end
      end
      ST_WIN: begin
        if (wr_en && wr_data == D_SECT) begin
          buf_set = 1'b1;
          tmr_rst = 1'b1;
        end else if (wr_en && wr_data != D_SUSP) begin
          nx = ST_IDLE;
          buf_clr = 1'b1;
        end else if (tcnt == WIN_LAST) begin
          nx = ST_ERASE;
          tmr_rst = 1'b1;
        end
      end
      ST_ERASE: begin
        if (tcnt == ERASE_LAST) begin
          nx = ST_IDLE;
          buf_clr = 1'b1;
        end
      end
      default: nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nx;
  end

  assign win_open = (st == ST_WIN);
  assign erasing  = (st == ST_ERASE);
  assign busy     = win_open | erasing;

  p_erase_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && tcnt != ERASE_LAST) |=> erasing);
  p_window_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && wr_en && wr_data != D_SECT && wr_data != D_SUSP) |=> !busy);
  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> tcnt <= WIN_LAST);
endmodule

// File: rtl/esq_sect_buf.sv
module esq_sect_buf #(
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_one,
  input  logic              set_all,
  input  logic              clr,
  input  logic              hold,
  input  logic [SECT_W-1:0] idx,
  output logic [NSECT-1:0]  mask
);
  logic [NSECT-1:0] nx;

  for (genvar i = 0; i < NSECT; i++) begin : g_bit
    always_comb begin
      if (clr)                           nx[i] = 1'b0;
      else if (set_all)                  nx[i] = 1'b1;
      else if (set_one && idx == SECT_W'(i)) nx[i] = 1'b1;
      else                               nx[i] = mask[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= nx;
  end

  p_mask_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> mask == '0);
  p_mask_only_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> (mask & $past(mask)) == $past(mask));
endmodule

// File: rtl/esq_status.sv
module esq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       busy,
  input  logic       erasing,
  output logic [7:0] rd_data
);
  logic tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tog <= 1'b0;
    else if (rd_en && busy) tog <= ~tog;
  end

  assign rd_data = busy ? {1'b0, tog, 2'b00, erasing, 3'b000} : 8'hFF;

  p_toggle_flips_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> rd_data[6] != $past(rd_data[6]) || !busy);
  p_done_bit_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_data[7]);
endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SECT_W    = 3,
  parameter int WIN_CYC   = 8,
  parameter int ERASE_CYC = 16,
  localparam int NSECT    = 1 << SECT_W,
  localparam int MAXV     = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC,
  localparam int TW       = $clog2(MAXV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              win_open,
  output logic              erasing,
  output logic [NSECT-1:0]  sect_mask
);
  logic [TW-1:0] tcnt;
  logic tmr_rst, buf_set, buf_clr, chip_set;

  esq_fsm #(.WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .key_addr(wr_addr[UNLK_W-1:0]), .wr_data(wr_data), .tcnt(tcnt),
    .tmr_rst(tmr_rst), .buf_set(buf_set), .buf_clr(buf_clr), .chip_set(chip_set),
    .busy(busy), .win_open(win_open), .erasing(erasing)
  );

  esq_timer #(.MAXV(MAXV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(tmr_rst), .run(busy), .cnt(tcnt)
  );

  esq_sect_buf #(.SECT_W(SECT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .set_one(buf_set), .set_all(chip_set),
    .clr(buf_clr), .hold(busy), .idx(wr_addr[ADDR_W-1 -: SECT_W]), .mask(sect_mask)
  );

  esq_status u_stat (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
    .erasing(erasing), .rd_data(rd_data)
  );

  p_chip_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(erasing) && !$past(win_open)) |-> &sect_mask);
  p_window_sets_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $countones(sect_mask) == 1);
endmodule

// File: tb/erase_cmd_seq_tb.sv
`timescale 1ns/1ps
module erase_cmd_seq_tb;
  localparam int ADDR_W = 12, SECT_W = 3, W = 6, E = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0, rd_data, rv1, rv2;
  logic busy, win_open, erasing;
  logic [7:0] sect_mask;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  erase_cmd_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .WIN_CYC(W), .ERASE_CYC(E)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .win_open(win_open),
    .erasing(erasing), .sect_mask(sect_mask)
  );

  // behavioural reference: 0 idle, 1..5 unlock progress, 6 window, 7 erasing
  int mst = 0, mcnt = 0;
  bit [7:0] mmask = 0;
  bit mtog = 0;
  int key_a[1:4] = '{12'h2AA, 12'h555, 12'h555, 12'h2AA};
  int key_d[1:4] = '{8'h55, 8'h80, 8'hAA, 8'h55};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; mcnt = 0; mmask = 0; mtog = 0;
    end else begin
      int a, sec;
      a = int'(wr_addr[10:0]);
      sec = int'(wr_addr[11:9]);
      if (rd_en && mst >= 6) mtog = !mtog;
      if (mst == 0) begin
        if (wr_en && a == 'h555 && wr_data == 8'hAA) mst = 1;
      end else if (mst <= 4) begin
        if (wr_en) mst = (a == key_a[mst] && int'(wr_data) == key_d[mst]) ? mst + 1 : 0;
      end else if (mst == 5) begin
        if (wr_en) begin
          if (a == 'h555 && wr_data == 8'h10) begin mst = 7; mcnt = 0; mmask = 8'hFF; end
          else if (wr_data == 8'h30) begin mst = 6; mcnt = 0; mmask[sec] = 1'b1; end
          else mst = 0;
        end
      end else if (mst == 6) begin
        if (wr_en && wr_data == 8'h30) begin mmask[sec] = 1'b1; mcnt = 0; end
        else if (wr_en && wr_data != 8'hB0) begin mst = 0; mmask = 0; end
        else if (mcnt == W - 1) begin mst = 7; mcnt = 0; end
        else mcnt++;
      end else begin
        if (mcnt == E - 1) begin mst = 0; mmask = 0; mcnt = 0; end
        else mcnt++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 busy vs model", int'(busy), int'(mst >= 6));
    chk("R5 window vs model", int'(win_open), int'(mst == 6));
    chk("R8 erasing vs model", int'(erasing), int'(mst == 7));
    chk("R6 mask vs model", int'(sect_mask), int'(mmask));
    if (rd_en)
      chk("R9 status vs model", int'(rd_data),
          (mst >= 6) ? int'({1'b0, mtog, 2'b00, mst == 7, 3'b000}) : 'hFF);
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_en = 1'b1; #0.5; v = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic prefix();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  task automatic finish_up();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    step(3); rst_n = 1'b1; step(1);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 mask", int'(sect_mask), 0);
    rd(rv1); chk("R1 idle read", int'(rv1), 'hFF);

    // R2 broken fifth write
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h56); wr(12'h555, 8'h10);
    step(2); chk("R2 no erase after bad key", int'(busy), 0);

    // R3 chip erase, R9 status, R8 ignored writes
    prefix(); wr(12'h555, 8'h10);
    chk("R3 erasing", int'(erasing), 1);
    chk("R3 all sectors", int'(sect_mask), 'hFF);
    rd(rv1); rd(rv2);
    chk("R9 first status", int'(rv1), 'h08);
    chk("R9 second status", int'(rv2), 'h48);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    step(E - 1 - 5);
    chk("R8 still erasing", int'(erasing), 1);
    chk("R8 mask kept", int'(sect_mask), 'hFF);
    step(1);
    chk("R8 done idle", int'(busy), 0);
    chk("R8 mask cleared", int'(sect_mask), 0);

    // R4 / R5 / R6 sector window
    prefix(); wr(12'hA00, 8'h30);
    chk("R4 window open", int'(win_open), 1);
    chk("R4 sector bit", int'(sect_mask), 'h20);
    rd(rv1); chk("R9 window status", int'(rv1), 'h00);
    step(2);
    wr(12'h400, 8'h30); wr(12'h123, 8'h30); wr(12'hA00, 8'h30); wr(12'hE00, 8'h30);
    chk("R6 mask any order", int'(sect_mask), 'hA5);
    step(W - 1); chk("R5 window last cycle", int'(win_open), 1);
    step(1);     chk("R5 erase starts", int'(erasing), 1);
    step(E);     chk("R5 erase length", int'(busy), 0);

    prefix();
    for (int s = 7; s >= 0; s--) wr(ADDR_W'(s << 9), 8'h30);
    chk("R6 all sectors queued", int'(sect_mask), 'hFF);
    step(W + E + 1);

    // R7 suspend has no effect, then abort
    prefix(); wr(12'h200, 8'h30); wr(12'h600, 8'hB0);
    chk("R7 suspend keeps window", int'(win_open), 1);
    chk("R7 suspend adds nothing", int'(sect_mask), 'h02);
    step(W - 2); chk("R7 window not restarted", int'(win_open), 1);
    step(1);     chk("R7 erase on time", int'(erasing), 1);
    step(E + 1);
    prefix(); wr(12'h200, 8'h30); wr(12'h555, 8'hAA);
    chk("R7 abort idle", int'(busy), 0);
    chk("R7 abort mask", int'(sect_mask), 0);

    // R10 reset mid-window and mid-erase
    prefix(); wr(12'h800, 8'h30); step(2);
    rst_n = 1'b0; #0.5;
    chk("R10 reset window", int'(busy), 0);
    chk("R10 reset mask", int'(sect_mask), 0);
    step(1); rst_n = 1'b1; step(1);
    prefix(); wr(12'h555, 8'h10); step(3);
    rst_n = 1'b0; #0.5;
    chk("R10 reset erase", int'(erasing), 0);
    step(1); rst_n = 1'b1; step(3);
    chk("R10 stays idle", int'(busy), 0);

    finish_up();
  end
endmodule